// File: doc/BRIEF.md
# Pseudo-SRAM Access Controller

This block sits between a synchronous host and an asynchronous, SRAM-style pseudo-static memory of 2M words by 16 bits. The host hands it one command at a time over a valid/ready port. A command is a single-word write with per-byte lane enables, a single-word read, or a page read burst of up to 16 words. The controller drives the active-low chip enable, output enable, write enable and byte strobes, a 21-bit word address and a split data bus (output value, output enable, input value). Read data comes back on a response port, one word per beat, with a flag on the final beat.

Every timing window is a count of system clock cycles. The counts are derived from nanosecond parameters and the clock period. Minimum windows round up. The cap on active time rounds down, because it is a maximum.

In a page burst, only the four low address bits advance, wrapping inside the 16-word page. Each beat after the first uses the shorter page timing. The controller ends a burst early when one more beat would push the chip-enable-low time past the cap. The memory needs this limit to refresh itself. After every access, chip enable is held high for a recovery time before the next command is accepted.

Top module: `psram_async_ctrl`

## Requirements
- R1: While reset is applied and after it is released, mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n and mem_ub_n are 1, mem_dq_oe is 0 and rsp_valid is 0.
- R2: A read keeps the address and chip enable steady, with output enable low, for T_ACC = max(ceil(70/Tclk), ceil(25/Tclk)) cycles. The bus is sampled in the last of those cycles, and rsp_valid pulses for one cycle on the following cycle with the stored word.
- R3: A read with cmd_len = N delivers N+1 words. Each beat after the first lasts T_PAGE = ceil(20/Tclk) cycles. Between beats, address bits [3:0] increase by one modulo 16 and bits [20:4] do not change.
- R4: Chip enable never stays low for more than floor(MAX_ACTIVE_NS/Tclk) cycles. A burst that would exceed this ends after the last beat that fits, and that beat carries rsp_last = 1.
- R5: A write drives the address and data for T_WRL cycles, where T_WRL is the larger of ceil(70/Tclk) and T_WE+2. mem_we_n is low for T_WE = max(ceil(50/Tclk), ceil(60/Tclk)-1) cycles, from the second cycle. Address and data do not change while mem_we_n is low.
- R6: cmd_be bit 0 enables the lower byte (mem_lb_n low) and bit 1 enables the upper byte (mem_ub_n low). A write changes only the enabled bytes. In read responses, a disabled byte is returned as 0.
- R7: mem_oe_n is high whenever mem_we_n is low. mem_dq_oe is 1 only during a write access and drops on the cycle the write ends.
- R8: Between accesses, chip enable stays high for at least ceil(10/Tclk) cycles. cmd_ready is 0 whenever chip enable is low.
- R9: For a write, cmd_len is ignored: exactly one word is written and the access lasts T_WRL cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command accepted when valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 21 | Word address (start address of a burst) |
| cmd_wdata | input | 16 | Write data |
| cmd_be | input | 2 | Byte enables, bit 0 lower, bit 1 upper |
| cmd_len | input | 4 | Extra read beats (0 = single word) |
| rsp_valid | output | 1 | Read word valid |
| rsp_data | output | 16 | Read word, disabled bytes zero |
| rsp_last | output | 1 | Final word of the read command |
| mem_addr | output | 21 | Memory word address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_dq_o | output | 16 | Data driven to memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_i | input | 16 | Data returned by memory |

## Verification
The assertions assume that the host changes command fields only while cmd_valid is offered and that the clock period makes T_ACC no larger than the active cap. The bench issues commands from the negative clock edge and holds them until cmd_ready is seen. Its cap parameter leaves room for six burst beats, so both full and truncated bursts occur. The bench's memory model returns a marker word until the address has been steady for the full access time or the page access time. A controller that samples too early therefore returns wrong data. The model also measures pulse widths, enable-high gaps and active lengths at the pins.

// File: rtl/psram_ctrl_pkg.sv
`timescale 1ns/1ps
package psram_ctrl_pkg;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_READ,
    PS_PAGE,
    PS_WRITE,
    PS_RECOVER
  } psram_state_e;

  // Round a minimum time up to whole clock cycles
  function automatic int ns_to_cyc(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_cycle_cnt.sv
`timescale 1ns/1ps
module psram_cycle_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (clr)     q_nxt = '0;
    else if (en) q_nxt = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/psram_access_fsm.sv
`timescale 1ns/1ps
module psram_access_fsm
  import psram_ctrl_pkg::*;
#(
  parameter int T_ACC  = 9,
  parameter int T_PAGE = 3,
  parameter int T_WRL  = 9,
  parameter int T_REC  = 2,
  parameter int T_MAX  = 1250,
  parameter int PW     = 4,
  parameter int CW     = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_fire,
  input  logic          cmd_write,
  input  logic          last_beat,
  input  logic [PW-1:0] phase,
  input  logic [CW-1:0] active,
  output psram_state_e  state,
  output logic          beat_end,
  output logic          more,
  output logic          phase_clr
);

  psram_state_e state_nxt;
  logic         room;

  always_comb begin
    beat_end = ((state == PS_READ) && (phase == PW'(T_ACC - 1))) ||
               ((state == PS_PAGE) && (phase == PW'(T_PAGE - 1)));
    // cycles spent so far incl. this one, plus one more page beat
    room     = (32'(active) + 32'd1 + 32'(T_PAGE)) <= 32'(T_MAX);
    more     = !last_beat && room;
    state_nxt = state;
    unique case (state)
      PS_IDLE:          if (cmd_fire) state_nxt = cmd_write ? PS_WRITE : PS_READ;
      PS_READ, PS_PAGE: if (beat_end) state_nxt = more ? PS_PAGE : PS_RECOVER;
      PS_WRITE:         if (phase == PW'(T_WRL - 1)) state_nxt = PS_RECOVER;
      PS_RECOVER:       if (phase == PW'(T_REC - 1)) state_nxt = PS_IDLE;
      default:          state_nxt = PS_IDLE;
    endcase
    phase_clr = beat_end || (state_nxt != state);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PS_IDLE;
    else        state <= state_nxt;
  end

  // R8: recovery always passes through idle before a new access
  assert_recover_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_RECOVER && phase_clr) |=> (state == PS_IDLE));

endmodule

// File: rtl/psram_async_ctrl.sv
`timescale 1ns/1ps
module psram_async_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int CLK_NS        = 8,
  parameter int ADDR_W        = 21,
  parameter int DATA_W        = 16,
  parameter int PAGE_BITS     = 4,
  parameter int RD_CYCLE_NS   = 70,
  parameter int OE_NS         = 25,
  parameter int PAGE_NS       = 20,
  parameter int WR_CYCLE_NS   = 70,
  parameter int WE_PULSE_NS   = 50,
  parameter int ADDR_END_NS   = 60,
  parameter int CE_HIGH_NS    = 10,
  parameter int MAX_ACTIVE_NS = 10000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic                 cmd_write,
  input  logic [ADDR_W-1:0]    cmd_addr,
  input  logic [DATA_W-1:0]    cmd_wdata,
  input  logic [DATA_W/8-1:0]  cmd_be,
  input  logic [PAGE_BITS-1:0] cmd_len,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_data,
  output logic                 rsp_last,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 mem_ce_n,
  output logic                 mem_oe_n,
  output logic                 mem_we_n,
  output logic                 mem_lb_n,
  output logic                 mem_ub_n,
  output logic [DATA_W-1:0]    mem_dq_o,
  output logic                 mem_dq_oe,
  input  logic [DATA_W-1:0]    mem_dq_i
);

  localparam int LANES  = DATA_W / 8;
  localparam int T_ACC  = imax(ns_to_cyc(RD_CYCLE_NS, CLK_NS), ns_to_cyc(OE_NS, CLK_NS));
  localparam int T_PAGE = ns_to_cyc(PAGE_NS, CLK_NS);
  localparam int T_WE   = imax(ns_to_cyc(WE_PULSE_NS, CLK_NS), ns_to_cyc(ADDR_END_NS, CLK_NS) - 1);
  localparam int T_WRL  = imax(ns_to_cyc(WR_CYCLE_NS, CLK_NS), T_WE + 2);
  localparam int T_REC  = imax(ns_to_cyc(CE_HIGH_NS, CLK_NS), 1);
  localparam int T_MAX  = MAX_ACTIVE_NS / CLK_NS;
  localparam int T_LONG = imax(imax(T_ACC, T_WRL), imax(T_PAGE, T_REC));
  localparam int PW     = $clog2(T_LONG + 1);
  localparam int CW     = $clog2(T_MAX + 2);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  psram_state_e         state;
  logic                 beat_end, more, phase_clr, cmd_fire, last_beat, active_n;
  logic [PW-1:0]        phase;
  logic [CW-1:0]        active_cnt;

  logic [ADDR_W-1:0]    addr_q, addr_n;
  logic [LANES-1:0]     be_q, be_n;
  logic [DATA_W-1:0]    wd_q, wd_n;
  logic [PAGE_BITS-1:0] left_q, left_n;
  logic                 ld_en;
  logic [DATA_W-1:0]    lane_mask;
  logic                 rv_n, rl_n;
  logic [DATA_W-1:0]    rd_n;

  psram_cycle_cnt #(.W(PW)) u_phase (
    .clk(clk), .rst_n(rst_i), .clr(phase_clr), .en(1'b1), .q(phase));

  psram_cycle_cnt #(.W(CW)) u_active (
    .clk(clk), .rst_n(rst_i), .clr(!active_n), .en(active_n), .q(active_cnt));

  psram_access_fsm #(
    .T_ACC(T_ACC), .T_PAGE(T_PAGE), .T_WRL(T_WRL), .T_REC(T_REC),
    .T_MAX(T_MAX), .PW(PW), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_i), .cmd_fire(cmd_fire), .cmd_write(cmd_write),
    .last_beat(last_beat), .phase(phase), .active(active_cnt),
    .state(state), .beat_end(beat_end), .more(more), .phase_clr(phase_clr));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_mask[g*8 +: 8] = {8{be_q[g]}};
  end

  always_comb begin
    cmd_ready = (state == PS_IDLE);
    cmd_fire  = cmd_valid && cmd_ready;
    last_beat = (left_q == '0);
    active_n  = (state == PS_READ) || (state == PS_PAGE) || (state == PS_WRITE);
    ld_en     = cmd_fire || (beat_end && more);
    addr_n = addr_q;
    be_n   = be_q;
    wd_n   = wd_q;
    left_n = left_q;
    if (cmd_fire) begin
      addr_n = cmd_addr;
      be_n   = cmd_be;
      wd_n   = cmd_wdata;
      left_n = cmd_write ? '0 : cmd_len;
    end else if (beat_end && more) begin
      addr_n[PAGE_BITS-1:0] = addr_q[PAGE_BITS-1:0] + 1'b1;
      left_n                = left_q - 1'b1;
    end
    rv_n = beat_end;
    rd_n = mem_dq_i & lane_mask;
    rl_n = beat_end && !more;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      addr_q <= '0;
      be_q   <= '0;
      wd_q   <= '0;
      left_q <= '0;
    end else if (ld_en) begin
      addr_q <= addr_n;
      be_q   <= be_n;
      wd_q   <= wd_n;
      left_q <= left_n;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      rsp_valid <= 1'b0;
      rsp_last  <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rv_n;
      rsp_last  <= rl_n;
      if (beat_end) rsp_data <= rd_n;
    end
  end

  always_comb begin
    mem_addr  = addr_q;
    mem_ce_n  = !active_n;
    mem_oe_n  = !((state == PS_READ) || (state == PS_PAGE));
    mem_we_n  = !((state == PS_WRITE) && (phase != '0) && (phase <= PW'(T_WE)));
    mem_lb_n  = !active_n || !be_q[0];
    mem_ub_n  = !active_n || !be_q[LANES-1];
    mem_dq_o  = wd_q;
    mem_dq_oe = (state == PS_WRITE);
  end

  // R7: memory output disabled while write enable is low
  assert_oe_off_in_write_R7: assert property (@(posedge clk) disable iff (!rst_i)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe));

  // R5: address and data frozen while write enable is low
  assert_write_stable_R5: assert property (@(posedge clk) disable iff (!rst_i)
    !mem_we_n |-> ($stable(mem_addr) && $stable(mem_dq_o)));

  // R3: only the in-page bits move while output enable stays low
  assert_page_upper_R3: assert property (@(posedge clk) disable iff (!rst_i)
    (!mem_oe_n && $past(!mem_oe_n)) |->
      (mem_addr[ADDR_W-1:PAGE_BITS] == $past(mem_addr[ADDR_W-1:PAGE_BITS])));

  // R4: active time bounded by the cap
  assert_active_cap_R4: assert property (@(posedge clk) disable iff (!rst_i)
    !mem_ce_n |-> (32'(active_cnt) < 32'(T_MAX)));

  // R8: chip enable high for at least two cycles after an access
  assert_ce_high_gap_R8: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(mem_ce_n) |=> mem_ce_n);

  // R2: a response follows a cycle with the memory selected
  assert_rsp_after_access_R2: assert property (@(posedge clk) disable iff (!rst_i)
    rsp_valid |-> $past(!mem_oe_n));

endmodule

// File: tb/psram_async_ctrl_bench.sv
`timescale 1ns/1ps
module psram_async_ctrl_bench;

  localparam int CYC     = 8;
  localparam int CAP_NS  = 200;
  // Expected cycle counts, computed from the requirements
  localparam int E_ACC   = (70 + CYC - 1) / CYC;
  localparam int E_PAGE  = (20 + CYC - 1) / CYC;
  localparam int E_WP    = (50 + CYC - 1) / CYC;
  localparam int E_WRL   = (70 + CYC - 1) / CYC;
  localparam int E_CEH   = (10 + CYC - 1) / CYC;
  localparam int E_MAX   = CAP_NS / CYC;
  localparam int E_BEATS = 1 + (E_MAX - E_ACC) / E_PAGE;

  logic        clk, rst_n;
  logic        cmd_valid, cmd_ready, cmd_write;
  logic [20:0] cmd_addr;
  logic [15:0] cmd_wdata;
  logic [1:0]  cmd_be;
  logic [3:0]  cmd_len;
  logic        rsp_valid, rsp_last;
  logic [15:0] rsp_data;
  logic [20:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] mem_dq_o, mem_dq_i;

  psram_async_ctrl #(.CLK_NS(CYC), .MAX_ACTIVE_NS(CAP_NS)) u_psram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_be(cmd_be), .cmd_len(cmd_len), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_last(rsp_last), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i));

  initial clk = 1'b0;
  always #(CYC/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] init_word(input logic [20:0] a);
    return {a[11:0], a[3:0]} ^ 16'hA55A;
  endfunction

  // ---------------- memory model ----------------
  logic [15:0] mdl_mem [logic [20:0]];
  logic [15:0] ref_mem [logic [20:0]];
  logic [15:0] dq_drv;
  assign mem_dq_i = dq_drv;

  int   ceh_run, act_run, we_run, age;
  bit   prev_rd, first_done, page_mode, saw_write, ready_bad, started;
  logic [20:0] last_addr;

  function automatic logic [15:0] mdl_word(input logic [20:0] a);
    return mdl_mem.exists(a) ? mdl_mem[a] : init_word(a);
  endfunction

  initial begin
    dq_drv = 16'hDEAD; ceh_run = 0; act_run = 0; we_run = 0; age = 0;
    prev_rd = 0; first_done = 0; page_mode = 0; saw_write = 0; ready_bad = 0; started = 0;
    last_addr = '0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_ce_n) begin
        if (act_run > 0) begin
          check(!ready_bad, "R8 ready low while active", 32'(ready_bad), 0);
          if (saw_write)
            check(act_run == E_WRL, "R9 write access length", act_run, E_WRL);
        end
        ceh_run++; act_run = 0; saw_write = 0; ready_bad = 0;
      end else begin
        if (act_run == 0 && started)
          check(ceh_run >= E_CEH, "R8 chip enable high gap", ceh_run, E_CEH);
        started = 1;
        ceh_run = 0; act_run++;
        if (act_run > E_MAX) check(0, "R4 active time over cap", act_run, E_MAX);
        if (cmd_ready) ready_bad = 1;
        if (mem_dq_oe) saw_write = 1;
      end
      if (mem_dq_oe && (!mem_oe_n || mem_ce_n)) check(0, "R7 bus driven outside write", 1, 0);
      if (!mem_we_n) begin
        if (!mem_oe_n) check(0, "R7 output enable low in write", 1, 0);
        we_run++;
      end else if (we_run > 0) begin
        check(we_run >= E_WP, "R5 write pulse width", we_run, E_WP);
        check(mem_dq_oe, "R7 data driven at write end", 32'(mem_dq_oe), 1);
        begin
          logic [15:0] w;
          w = mdl_word(mem_addr);
          if (!mem_lb_n) w[7:0]  = mem_dq_o[7:0];
          if (!mem_ub_n) w[15:8] = mem_dq_o[15:8];
          mdl_mem[mem_addr] = w;
        end
        we_run = 0;
      end
      if (!mem_ce_n && !mem_oe_n) begin
        if (prev_rd && mem_addr == last_addr) age++;
        else if (prev_rd && first_done && mem_addr[20:4] == last_addr[20:4]) begin
          age = 1; page_mode = 1;
        end else begin
          age = 1; page_mode = 0; first_done = 0;
        end
        if (!page_mode && age >= E_ACC) first_done = 1;
        dq_drv = ((page_mode && age >= E_PAGE) || (!page_mode && age >= E_ACC))
                 ? mdl_word(mem_addr) : 16'hDEAD;
        prev_rd = 1;
      end else begin
        prev_rd = 0; dq_drv = 16'hDEAD;
      end
      last_addr = mem_addr;
    end
  end

  // ---------------- response checking ----------------
  logic [15:0] exp_d[$];
  bit          exp_l[$];
  string       exp_t[$];

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_d.size() == 0) check(0, "R2 unexpected response", 32'(rsp_data), 0);
      else begin
        logic [15:0] d; bit l; string t;
        d = exp_d.pop_front(); l = exp_l.pop_front(); t = exp_t.pop_front();
        check(rsp_data == d, {t, " read data"}, 32'(rsp_data), 32'(d));
        check(rsp_last == l, {t, " last flag"}, 32'(rsp_last), 32'(l));
      end
    end
  end

  function automatic logic [15:0] ref_word(input logic [20:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : init_word(a);
  endfunction

  task automatic issue(input bit wr, input logic [20:0] a, input logic [15:0] d,
                       input logic [1:0] be, input logic [3:0] len, input string tag);
    @(negedge clk);
    cmd_valid = 1; cmd_write = wr; cmd_addr = a; cmd_wdata = d; cmd_be = be; cmd_len = len;
    while (!cmd_ready) @(negedge clk);
    if (wr) begin
      logic [15:0] w;
      w = ref_word(a);
      if (be[0]) w[7:0]  = d[7:0];
      if (be[1]) w[15:8] = d[15:8];
      ref_mem[a] = w;
    end else begin
      int n;
      n = (int'(len) + 1 < E_BEATS) ? int'(len) + 1 : E_BEATS;
      for (int i = 0; i < n; i++) begin
        logic [20:0] ba;
        ba = {a[20:4], 4'(a[3:0] + 4'(i))};
        exp_d.push_back(ref_word(ba) & {{8{be[1]}}, {8{be[0]}}});
        exp_l.push_back(i == n - 1);
        exp_t.push_back(tag);
      end
    end
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CYC * 100000);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  localparam logic [20:0] BASE = 21'h0A000;

  initial begin
    cmd_valid = 0; cmd_write = 0; cmd_addr = '0; cmd_wdata = '0; cmd_be = '0; cmd_len = '0;
    rst_n = 0;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    check({mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n} == 5'h1F, "R1 strobes in reset",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 5'h1F);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(!mem_dq_oe && !rsp_valid && mem_ce_n && mem_oe_n && mem_we_n, "R1 idle after reset",
          {mem_dq_oe, rsp_valid, mem_ce_n}, 3'b001);
    check(cmd_ready, "R1 ready after reset", 32'(cmd_ready), 1);

    // R5 R2: full write then read back
    issue(1, BASE + 5, 16'h1234, 2'b11, 0, "R5");
    issue(0, BASE + 5, 0, 2'b11, 0, "R2");
    // R6: lower-byte write, full read, upper-only read
    issue(1, BASE + 5, 16'hFFAB, 2'b01, 0, "R6");
    issue(0, BASE + 5, 0, 2'b11, 0, "R6");
    issue(0, BASE + 5, 0, 2'b10, 0, "R6");
    // R9: write with nonzero length touches one word only
    issue(1, BASE + 6, 16'h5150, 2'b11, 4'hF, "R9");
    issue(0, BASE + 5, 0, 2'b11, 4'd3, "R9");
    // R3: short burst from page start
    issue(0, BASE + 16, 0, 2'b11, 4'd4, "R3");
    // R4: full burst wrapping from offset 14, cut by the cap
    issue(0, BASE + 14, 0, 2'b11, 4'hF, "R4");

    for (int k = 0; k < 80; k++) begin
      logic [20:0] a;
      logic        wr;
      a  = BASE + 21'($urandom % 96);
      wr = ($urandom % 2) == 0;
      issue(wr, a, 16'($urandom), 2'($urandom % 3 + 1), 4'($urandom), wr ? "R5" : "R3");
    end

    for (int w = 0; w < 400 && exp_d.size() != 0; w++) @(negedge clk);
    repeat (5) @(negedge clk);
    check(exp_d.size() == 0, "R2 responses outstanding", exp_d.size(), 0);
    finish_run();
  end

endmodule